// File: doc/BRIEF.md
# Sticky Falling-Edge Event Catcher with Ordered Dispatch

This block watches a bank of asynchronous input pins for high-to-low transitions and records each one in a sticky flag bit. A flag stays set until software clears it, so a low pulse that is far shorter than the software polling loop is still seen.

A per-pin enable mask decides which pins may raise a flag. The block reports whether any flag is pending. It also reports the index of the lowest pending flag, which is the handler that should be serviced next. Software services handlers in ascending bit order: it takes the index, runs the handler, and clears that bit with a write-one-to-clear access. The next index then appears on its own, and the loop ends when nothing is pending.

A read strobe copies the flag vector into a holding register. Software then sees a stable snapshot.

Top module: `pin_fall_catcher`

## Requirements
- R1: A falling edge on an enabled pin sets its flag. If the pin is first sampled low at clock edge k, the flag is visible after clock edge k+2.
- R2: Rising edges and steady levels on any pin never set a flag.
- R3: A pin whose bit in `en_mask_i` is 0 cannot set its flag. Changing the mask does not alter flags that are already set.
- R4: A flag is sticky. A low pulse on a pin that lasts a single clock cycle is recorded, and the flag stays set after the pin returns high.
- R5: When `clr_en_i` is 1, each 1 in `clr_bits_i` clears the flag at that bit position on the next clock edge, and each 0 leaves its flag unchanged. When `clr_en_i` is 0, no flag is cleared.
- R6: If a falling edge and a clear hit the same bit on the same clock edge, the flag ends up set.
- R7: `pend_any_o` is 1 exactly when at least one bit of `flags_o` is 1.
- R8: `next_idx_o` is the binary index of the lowest-numbered set bit of `flags_o` (bit 0 is served first, then 1, 2 and upward). It is 0 when no flag is set.
- R9: A clock edge with `rd_en_i` high loads `rd_data_o` with the current flags. Without the strobe, `rd_data_o` holds its value.
- R10: After reset, `flags_o` and `rd_data_o` are 0, and no flag is set because of the pin levels present during or just after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | W | Raw asynchronous event pins |
| en_mask_i | input | W | Per-pin capture enable |
| rd_en_i | input | 1 | Snapshot strobe for `rd_data_o` |
| clr_en_i | input | 1 | Clear access enable |
| clr_bits_i | input | W | Write-one-to-clear bit pattern |
| flags_o | output | W | Live sticky flag vector |
| rd_data_o | output | W | Flag snapshot taken on the read strobe |
| pend_any_o | output | 1 | Some flag is pending |
| next_idx_o | output | IDX_W | Index of the lowest pending flag |

## Verification
The bound checker checks these rules on every cycle:
- a flag can rise only from a detected fall on an enabled pin;
- a flag can drop only under an enabled clear;
- a detected fall is never lost to a clear;
- the pending indicator and the index always point at a set flag;
- the snapshot register loads only on the strobe.

Only the bench scenarios can show that the synchronizer latency is exactly three edges and that a single-cycle pulse survives. They also show that rising edges and masked pins leave the flags at zero, and that the service order walks the pending bits upward as software clears them.

// File: rtl/pin_fall_catcher_pkg.sv
package pin_fall_catcher_pkg;
  // Index of the lowest set bit among the first n bits; 0 when none set.
  function automatic int unsigned lowest_set(input logic [31:0] v, input int unsigned n);
    int unsigned r;
    r = 0;
    for (int i = 31; i >= 0; i--) begin
      if (i < int'(n) && v[i]) r = i;
    end
    return r;
  endfunction
endpackage

// File: rtl/pfc_sync.sv
module pfc_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  // Reset to low: a falling edge then needs a high level first, so no false event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg <= '0;
    else        stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pfc_fall_detect.sv
module pfc_fall_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= cur_i;
  end

  // Changed bits, then keep only those now low, then gate by enable.
  assign fall_o = (prev ^ cur_i) & ~cur_i & mask_i;
endmodule

// File: rtl/pfc_sticky_bank.sv
module pfc_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] clr_bits_i,
  output logic [W-1:0] flag_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        flag_o[b] <= 1'b0;
      else if (set_i[b])                 flag_o[b] <= 1'b1;
      else if (clr_en_i && clr_bits_i[b]) flag_o[b] <= 1'b0;
    end
  end
endmodule

// File: rtl/pfc_prio_enc.sv
module pfc_prio_enc #(
  parameter int W     = 8,
  parameter int IDX_W = 3
) (
  input  logic [W-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  import pin_fall_catcher_pkg::*;

  logic [31:0] req_ext;
  assign req_ext = 32'(req_i);
  assign any_o   = |req_i;

  always_comb begin
    idx_o = IDX_W'(lowest_set(req_ext, W));
  end
endmodule

// File: rtl/pin_fall_catcher.sv
module pin_fall_catcher #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2,
  localparam int IDX_W      = (W > 1) ? $clog2(W) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [W-1:0]     pin_i,
  input  logic [W-1:0]     en_mask_i,
  input  logic             rd_en_i,
  input  logic             clr_en_i,
  input  logic [W-1:0]     clr_bits_i,
  output logic [W-1:0]     flags_o,
  output logic [W-1:0]     rd_data_o,
  output logic             pend_any_o,
  output logic [IDX_W-1:0] next_idx_o
);
  logic [W-1:0] pin_s;
  logic [W-1:0] fall_vec;

  pfc_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(pin_s)
  );

  pfc_fall_detect #(.W(W)) det_i (
    .clk(clk), .rst_n(rst_n), .cur_i(pin_s), .mask_i(en_mask_i), .fall_o(fall_vec)
  );

  pfc_sticky_bank #(.W(W)) bank_i (
    .clk(clk), .rst_n(rst_n), .set_i(fall_vec),
    .clr_en_i(clr_en_i), .clr_bits_i(clr_bits_i), .flag_o(flags_o)
  );

  pfc_prio_enc #(.W(W), .IDX_W(IDX_W)) enc_i (
    .req_i(flags_o), .any_o(pend_any_o), .idx_o(next_idx_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_data_o <= '0;
    else if (rd_en_i) rd_data_o <= flags_o;
  end
endmodule

// File: rtl/pin_fall_catcher_chk.sv
module pin_fall_catcher_chk #(
  parameter int W = 8,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     en_mask_i,
  input logic             rd_en_i,
  input logic             clr_en_i,
  input logic [W-1:0]     clr_bits_i,
  input logic [W-1:0]     flags_o,
  input logic [W-1:0]     rd_data_o,
  input logic             pend_any_o,
  input logic [IDX_W-1:0] next_idx_o,
  input logic [W-1:0]     fall_vec
);
  // R3: a newly set flag must come from an enabled pin
  a_r3_masked_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(en_mask_i)) == '0));

  // R2: a flag rises only after a detected fall
  a_r2_set_needs_fall: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(fall_vec)) == '0));

  // R5: a flag drops only under an enabled clear
  a_r5_drop_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~flags_o & $past(flags_o) & ~($past(clr_bits_i) & {W{$past(clr_en_i)}})) == '0));

  // R6: a detected fall always leaves the flag set
  a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(fall_vec) & ~flags_o) == '0));

  // R7 and R8: the index points at a pending flag, and is 0 when nothing is pending
  a_r8_idx_pending: assert property (@(posedge clk) disable iff (!rst_n)
    pend_any_o |-> flags_o[next_idx_o]);
  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_any_o |-> (flags_o == '0 && next_idx_o == '0));

  // R9: the snapshot loads on the strobe and holds otherwise
  a_r9_snap_load: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> (rd_data_o == $past(flags_o)));
  a_r9_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> $stable(rd_data_o));
endmodule

bind pin_fall_catcher pin_fall_catcher_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_mask_i(en_mask_i), .rd_en_i(rd_en_i),
  .clr_en_i(clr_en_i), .clr_bits_i(clr_bits_i), .flags_o(flags_o),
  .rd_data_o(rd_data_o), .pend_any_o(pend_any_o), .next_idx_o(next_idx_o),
  .fall_vec(fall_vec)
);

// File: tb/pin_fall_catcher_tb_top.sv
`timescale 1ns/1ps
module pin_fall_catcher_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin_i = '1, en_mask_i = '1, clr_bits_i = '0;
  logic         rd_en_i = 1'b0, clr_en_i = 1'b0;
  logic [W-1:0] flags_o, rd_data_o;
  logic         pend_any_o;
  logic [2:0]   next_idx_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pin_fall_catcher dut_i (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .en_mask_i(en_mask_i),
    .rd_en_i(rd_en_i), .clr_en_i(clr_en_i), .clr_bits_i(clr_bits_i),
    .flags_o(flags_o), .rd_data_o(rd_data_o), .pend_any_o(pend_any_o),
    .next_idx_o(next_idx_o)
  );

  // {mask, pins before, pins after, expected flags}
  localparam logic [31:0] VEC [8] = '{
    32'hFF_FF_FE_01, 32'hFF_FF_5A_A5, 32'hFF_00_FF_00, 32'h0F_FF_00_0F,
    32'hF0_A5_00_A0, 32'hFF_0F_F0_0F, 32'h00_FF_00_00, 32'hFF_FF_7F_80
  };

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] low_idx(logic [7:0] v);
    logic [2:0] r = 3'd0;
    for (int i = 7; i >= 0; i--) if (v[i]) r = 3'(i);
    return r;
  endfunction

  task automatic clear_all();
    clr_en_i = 1'b1; clr_bits_i = '1; tick();
    clr_en_i = 1'b0; clr_bits_i = '0;
  endtask

  task automatic clear_one(logic [7:0] b);
    clr_en_i = 1'b1; clr_bits_i = b; tick();
    clr_en_i = 1'b0; clr_bits_i = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(5);
    chk("R10 flags after reset", flags_o, 0);
    chk("R10 rd_data after reset", rd_data_o, 0);
    chk("R7 pend after reset", pend_any_o, 0);
    chk("R8 idx after reset", next_idx_o, 0);

    // Vector table
    foreach (VEC[v]) begin
      en_mask_i = VEC[v][31:24];
      pin_i     = VEC[v][23:16];
      tick(4);
      clear_all();
      pin_i = VEC[v][15:8];
      tick(4);
      chk($sformatf("R1/R2/R3 vec%0d flags", v), flags_o, VEC[v][7:0]);
      chk($sformatf("R7 vec%0d pend", v), pend_any_o, |VEC[v][7:0]);
      chk($sformatf("R8 vec%0d idx", v), next_idx_o, low_idx(VEC[v][7:0]));
    end

    // R1 latency
    en_mask_i = '1; pin_i = '1; tick(4); clear_all();
    pin_i[6] = 1'b0; tick();
    chk("R1 latency edge k", flags_o, 0);
    tick();
    chk("R1 latency edge k+1", flags_o, 0);
    tick();
    chk("R1 latency edge k+2", flags_o, 8'h40);

    // R4 single-cycle pulse is sticky
    pin_i[3] = 1'b0; tick(); pin_i[3] = 1'b1; tick(3);
    chk("R4 short pulse captured", flags_o, 8'h48);
    tick(10);
    chk("R4 flag held", flags_o, 8'h48);

    // R5 write-one-to-clear
    clear_one(8'h08);
    chk("R5 clear one bit", flags_o, 8'h40);
    clear_one(8'h00);
    chk("R5 zero pattern no effect", flags_o, 8'h40);
    clr_en_i = 1'b0; clr_bits_i = '1; tick(); clr_bits_i = '0;
    chk("R5 disabled clear no effect", flags_o, 8'h40);

    // R8 service order
    pin_i = '1; tick(4); clear_all();
    pin_i = 8'h5A; tick(4);
    chk("R8 order flags", flags_o, 8'hA5);
    chk("R8 order idx0", next_idx_o, 0);
    clear_one(8'h01); chk("R8 order idx2", next_idx_o, 2);
    clear_one(8'h04); chk("R8 order idx5", next_idx_o, 5);
    clear_one(8'h20); chk("R8 order idx7", next_idx_o, 7);
    clear_one(8'h80);
    chk("R7 drained pend", pend_any_o, 0);
    chk("R8 drained idx", next_idx_o, 0);

    // R6 set wins over a coincident clear
    pin_i = '1; tick(4); clear_all();
    pin_i[1] = 1'b0; tick(2);
    clr_en_i = 1'b1; clr_bits_i = 8'h02; tick();
    clr_en_i = 1'b0; clr_bits_i = '0;
    chk("R6 set wins", flags_o, 8'h02);

    // R3 mask change keeps flags; masked fall ignored
    en_mask_i = '0; tick();
    pin_i[0] = 1'b0; tick(5);
    chk("R3 masked fall and retained flag", flags_o, 8'h02);

    // R9 snapshot
    rd_en_i = 1'b1; tick(); rd_en_i = 1'b0;
    chk("R9 snapshot load", rd_data_o, 8'h02);
    clear_all(); tick(2);
    chk("R9 snapshot hold", rd_data_o, 8'h02);
    chk("R5 flags cleared", flags_o, 0);
    rd_en_i = 1'b1; tick(); rd_en_i = 1'b0;
    chk("R9 snapshot reload", rd_data_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule